// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller with Byte Lanes

This block sits between a clocked host and an external asynchronous static RAM organised as 16-bit words with two byte lanes. The host offers one read or one write at a time over a valid/ready handshake. The controller latches the request and drives the chip enables, write enable, output enable, byte enables and address. Each phase of the access is timed by counting clock cycles. The cycle counts are worked out at elaboration from nanosecond timing parameters and the clock period.

On a read, the controller selects the chip with output enable low and its own data drivers off. It samples the input bus once the access time has elapsed and returns the word with a one-clock valid pulse. On a write, write enable falls first. The controller turns its data drivers on only after the memory's output turnaround time has passed. It raises write enable while the data is still driven, and releases the bus one phase later. The chip is deselected whenever the controller is idle.

Top module: `sram_ctl`

## Requirements
- R1: When idle, including right after reset, ready is high and the memory is deselected: ce1_n high, ce2 low, we_n high, oe_n high, both byte enables high and data drivers off.
- R2: A read holds ce1_n low, ce2 high, oe_n low and we_n high for exactly RD_CYC clock cycles. It samples the data bus at the end of that window, and pulses rsp_valid for one clock in the cycle ready returns high.
- R3: A write holds we_n low, ce1_n low and ce2 high for exactly WZ_CYC + WD_CYC cycles, with oe_n high throughout.
- R4: During a write, the data drivers stay off for the first WZ_CYC cycles of we_n low. They are then on for the last WD_CYC cycles of we_n low, and stay on for WE_CYC cycles after we_n rises.
- R5: Mask bit 0 drives mem_be_n[0] low and selects data bits 7:0; mask bit 1 drives mem_be_n[1] low and selects bits 15:8. Only the selected lanes are written, and a lane's driver enable is set only if its mask bit is set.
- R6: Read data has every unselected byte lane forced to zero, whatever the bus carries on it.
- R7: The data drivers are never on while oe_n is low, and we_n and oe_n are never low together.
- R8: A request is accepted only while ready is high. Address, write data and mask are latched on acceptance. The address and data pins hold those values for the whole access, even if the host inputs change. ready stays low for RD_CYC cycles on a read and for WZ_CYC + WD_CYC + WE_CYC cycles on a write.
- R9: A request with both mask bits clear makes no memory access and keeps ready high. For a read, it returns rsp_valid with zero data on the next clock.
- R10: The cycle counts come from ceiling division of each nanosecond limit by the clock period, with at least one cycle per phase. RD_CYC is the larger of the access-time count and the cycle-time count. WZ_CYC is the turnaround count. WD_CYC is the larger of the data-setup count and the pulse-width count left after WZ_CYC. WE_CYC is whatever remains of the cycle-time count, but at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle, request may be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | LANES | Byte-lane select, bit n selects bits 8n+7:8n |
| rsp_valid | output | 1 | One-clock read data valid |
| rsp_rdata | output | DATA_W | Read data, unselected lanes zero |
| mem_ce1_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Chip enable, active high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | LANES | Byte-lane enables, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_o | output | DATA_W | Data bus output value |
| mem_dq_oe | output | LANES | Per-lane data driver enable |
| mem_dq_i | input | DATA_W | Data bus input value |

## Verification
The bench builds the block with a 6-bit address, so every word can be written, read back and partially rewritten in one run. It uses an 8 ns clock against the default nanosecond limits, which gives 7, 3, 4 and 1 cycles for the read, turnaround, data and end phases. With those counts, a wrong ceiling or a lost phase changes an observed pulse width. A behavioural memory model in the bench returns garbage before the access time has elapsed and on disabled lanes. This exposes early sampling, lane masking faults and any bus contention.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WTURN = 3'd2,
    ST_WDATA = 3'd3,
    ST_WEND  = 3'd4
  } sram_st_e;

  // ceiling division of a nanosecond limit by the clock period
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    if (ns <= 0) return 0;
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int RD_CYC  = 7,
  parameter int WZ_CYC  = 3,
  parameter int WD_CYC  = 4,
  parameter int WE_CYC  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             mask_none,
  input  logic             tmr_zero,
  output sram_st_e         state,
  output logic             ready,
  output logic             accept,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             cap_rd,
  output logic             zero_rd
);
  localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WZ_LD = CNT_W'(WZ_CYC - 1);
  localparam logic [CNT_W-1:0] WD_LD = CNT_W'(WD_CYC - 1);
  localparam logic [CNT_W-1:0] WE_LD = CNT_W'(WE_CYC - 1);

  sram_st_e st_q, st_d;

  assign ready  = (st_q == ST_IDLE);
  assign accept = ready && req_valid;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap_rd   = 1'b0;
    zero_rd  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (mask_none) begin
            zero_rd = !req_write;
          end else if (req_write) begin
            st_d     = ST_WTURN;
            tmr_load = 1'b1;
            tmr_val  = WZ_LD;
          end else begin
            st_d     = ST_READ;
            tmr_load = 1'b1;
            tmr_val  = RD_LD;
          end
        end
      end
      ST_READ: begin
        if (tmr_zero) begin
          st_d   = ST_IDLE;
          cap_rd = 1'b1;
        end
      end
      ST_WTURN: begin
        if (tmr_zero) begin
          st_d     = ST_WDATA;
          tmr_load = 1'b1;
          tmr_val  = WD_LD;
        end
      end
      ST_WDATA: begin
        if (tmr_zero) begin
          st_d     = ST_WEND;
          tmr_load = 1'b1;
          tmr_val  = WE_LD;
        end
      end
      ST_WEND: begin
        if (tmr_zero) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;

  // R8: a busy controller leaves idle only through a finished phase
  assert_busy_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && !tmr_zero) |=> (st_q == $past(st_q)));
endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sram_st_e          state,
  input  logic              accept,
  input  logic              cap_rd,
  input  logic              zero_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [LANES-1:0]  mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q;
  logic [DATA_W-1:0] rd_masked;
  logic              rsp_valid_d;
  logic [DATA_W-1:0] rsp_rdata_d;
  logic              busy;

  // request latch, clock-enabled by acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rd_masked[l*8 +: 8] = mask_q[l] ? mem_dq_i[l*8 +: 8] : 8'h00;
  end

  always_comb begin
    rsp_valid_d = cap_rd || zero_rd;
    rsp_rdata_d = rsp_rdata;
    if (cap_rd)       rsp_rdata_d = rd_masked;
    else if (zero_rd) rsp_rdata_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_rdata <= rsp_rdata_d;
    end
  end

  assign busy      = (state != ST_IDLE);
  assign mem_ce1_n = !busy;
  assign mem_ce2   = busy;
  assign mem_oe_n  = (state != ST_READ);
  assign mem_we_n  = !(state == ST_WTURN || state == ST_WDATA);
  assign mem_be_n  = busy ? ~mask_q : '1;
  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign mem_dq_oe = (state == ST_WDATA || state == ST_WEND) ? mask_q : '0;

  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe != '0) |-> mem_oe_n);

  assert_we_oe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  assert_drive_late_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|mem_dq_oe) |-> (!mem_we_n && $past(!mem_we_n)));

  assert_lane_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_dq_oe & mem_be_n) == '0));
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int CLK_NS   = 8,
  parameter int T_CYC_NS = 55,
  parameter int T_ACC_NS = 55,
  parameter int T_WP_NS  = 40,
  parameter int T_DS_NS  = 25,
  parameter int T_HZ_NS  = 20,
  parameter int CNT_W    = 8,
  localparam int LANES   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [LANES-1:0]  mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  // R10: phase lengths in clock cycles
  localparam int CYC_RC = max2(1, ns_to_cyc(T_CYC_NS, CLK_NS));
  localparam int RD_CYC = max2(CYC_RC, ns_to_cyc(T_ACC_NS, CLK_NS));
  localparam int WZ_CYC = max2(1, ns_to_cyc(T_HZ_NS, CLK_NS));
  localparam int WD_CYC = max2(1, max2(ns_to_cyc(T_DS_NS, CLK_NS),
                                       ns_to_cyc(T_WP_NS, CLK_NS) - WZ_CYC));
  localparam int WE_CYC = max2(1, CYC_RC - WZ_CYC - WD_CYC);

  logic [1:0]       rst_sync_q;
  logic             rst_n_i;
  sram_st_e         state;
  logic             accept, tmr_load, tmr_zero, cap_rd, zero_rd;
  logic [CNT_W-1:0] tmr_val;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  sram_ctl_fsm #(
    .CNT_W (CNT_W),  .RD_CYC(RD_CYC), .WZ_CYC(WZ_CYC),
    .WD_CYC(WD_CYC), .WE_CYC(WE_CYC)
  ) fsm_i (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .req_valid(req_valid),
    .req_write(req_write),
    .mask_none(req_mask == '0),
    .tmr_zero (tmr_zero),
    .state    (state),
    .ready    (req_ready),
    .accept   (accept),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .cap_rd   (cap_rd),
    .zero_rd  (zero_rd)
  );

  sram_ctl_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .load    (tmr_load),
    .load_val(tmr_val),
    .zero    (tmr_zero)
  );

  sram_ctl_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) pins_i (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .state    (state),
    .accept   (accept),
    .cap_rd   (cap_rd),
    .zero_rd  (zero_rd),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_mask (req_mask),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .mem_ce1_n(mem_ce1_n),
    .mem_ce2  (mem_ce2),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_be_n (mem_be_n),
    .mem_addr (mem_addr),
    .mem_dq_o (mem_dq_o),
    .mem_dq_oe(mem_dq_oe),
    .mem_dq_i (mem_dq_i)
  );

  assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n_i)
    req_ready |-> (mem_ce1_n && !mem_ce2 && (mem_be_n == '1) && (mem_dq_oe == '0)));

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!req_ready && $past(!req_ready)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

  assert_rsp_at_idle_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
    rsp_valid |-> req_ready);
endmodule

// File: tb/sram_ctl_tb_top.sv
module sram_ctl_tb_top;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int CLKNS = 8;
  localparam int DEPTH = 1 << AW;
  // R10: expected counts, worked out from the default ns limits and 8 ns
  localparam int RD_E = 7;   // ceil(55/8)
  localparam int WZ_E = 3;   // ceil(20/8)
  localparam int WD_E = 4;   // max(ceil(25/8)=4, ceil(40/8)-3=2)
  localparam int WE_E = 1;   // max(1, 7-3-4)

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, req_ready, rsp_valid;
  logic [AW-1:0] req_addr, mem_addr;
  logic [DW-1:0] req_wdata, rsp_rdata, mem_dq_o, mem_dq_i;
  logic [1:0] req_mask, mem_be_n, mem_dq_oe;
  logic mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n;

  always #4 clk = ~clk;

  sram_ctl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLKNS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int checks = 0;
  int fails  = 0;
  logic mon_on = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // behavioural memory
  logic [DW-1:0] mem [DEPTH];
  int rd_age = 0;
  wire rd_sel = !mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n;

  always_ff @(posedge clk) begin
    if (rd_sel) rd_age <= rd_age + 1;
    else        rd_age <= 0;
  end

  always_comb begin
    mem_dq_i = 16'hB00B;
    if (rd_sel && rd_age >= RD_E - 1) begin
      mem_dq_i[7:0]  = mem_be_n[0] ? 8'hEE : mem[mem_addr][7:0];
      mem_dq_i[15:8] = mem_be_n[1] ? 8'hEE : mem[mem_addr][15:8];
    end
  end

  // pin-level monitor
  logic prev_we_n = 1'b1, prev_oe_n = 1'b1;
  int wl = 0, dd = 0, ol = 0, sel_cnt = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (!mem_ce1_n) sel_cnt++;
      if (mem_dq_oe != 0 && !mem_oe_n) chk(0, "R7 drive while oe low", mem_dq_oe, 0);
      if (!mem_we_n && !mem_oe_n) chk(0, "R7 we and oe both low", 0, 1);
      if (!mem_we_n) begin
        wl++;
        if (mem_dq_oe != 0) dd++;
        else if (dd > 0) chk(0, "R4 drive dropped early", dd, WD_E);
      end
      if (!mem_oe_n) ol++;
      if (mem_we_n && !prev_we_n) begin
        chk(wl == WZ_E + WD_E, "R3 we low width", wl, WZ_E + WD_E);
        chk(dd == WD_E, "R4 drive cycles before we rises", dd, WD_E);
        chk(mem_dq_oe == ~mem_be_n, "R4 R5 drive held after we rises", mem_dq_oe, ~mem_be_n);
        chk(!mem_ce1_n && mem_ce2, "R3 chip enables at write end", mem_ce1_n, 0);
        if (!mem_be_n[0]) mem[mem_addr][7:0]  = mem_dq_o[7:0];
        if (!mem_be_n[1]) mem[mem_addr][15:8] = mem_dq_o[15:8];
        wl = 0; dd = 0;
      end
      if (mem_oe_n && !prev_oe_n) begin
        chk(ol == RD_E, "R2 oe low width", ol, RD_E);
        ol = 0;
      end
    end
    prev_we_n = mem_we_n;
    prev_oe_n = mem_oe_n;
  end

  // one request; returns busy cycles and read data
  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [1:0] m, output int busy, output logic [DW-1:0] rd,
                        output bit got);
    busy = 0; got = 0; rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;
    req_wdata = ~d;
    req_mask  = ~m;
    while (!req_ready && busy < 100) begin
      chk(mem_addr == a, "R8 address held", mem_addr, a);
      if (wr) chk(mem_dq_o == d, "R8 data held", mem_dq_o, d);
      busy++;
      @(negedge clk);
    end
    got = rsp_valid;
    rd  = rsp_rdata;
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return 16'(a * 16'h0907 ^ 16'h3CA5);
  endfunction

  function automatic logic [DW-1:0] lanes(input logic [DW-1:0] v, input logic [1:0] m);
    return {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00};
  endfunction

  logic [DW-1:0] ref_mem [DEPTH];

  initial begin : watchdog
    #(8 * 150000);
    chk(0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int bz; logic [DW-1:0] rd; bit got; int sc;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_mask = '0;
    for (int i = 0; i < DEPTH; i++) begin mem[i] = 16'hDEAD; ref_mem[i] = 16'hDEAD; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;
    // R1 reset state
    chk(req_ready, "R1 ready after reset", req_ready, 1);
    chk(mem_ce1_n && !mem_ce2, "R1 chip deselected", {mem_ce1_n, mem_ce2}, 2);
    chk(mem_we_n && mem_oe_n, "R1 strobes high", {mem_we_n, mem_oe_n}, 3);
    chk(mem_be_n == 2'b11 && mem_dq_oe == 0, "R1 lanes off", {mem_be_n, mem_dq_oe}, 12);
    chk(!rsp_valid, "R1 no response", rsp_valid, 0);

    // full-word writes over every address
    for (int a = 0; a < DEPTH; a++) begin
      do_req(1, a[AW-1:0], pat(a), 2'b11, bz, rd, got);
      ref_mem[a] = pat(a);
      chk(bz == WZ_E + WD_E + WE_E, "R8 write busy length", bz, WZ_E + WD_E + WE_E);
      chk(!got, "R2 no response on write", got, 0);
      chk(mem_ce1_n && !mem_ce2 && mem_be_n == 2'b11, "R1 deselect after write", mem_ce1_n, 1);
    end
    // full reads
    for (int a = 0; a < DEPTH; a++) begin
      do_req(0, a[AW-1:0], '0, 2'b11, bz, rd, got);
      chk(bz == RD_E, "R2 R10 read busy length", bz, RD_E);
      chk(got, "R2 response pulse", got, 1);
      chk(rd == ref_mem[a], "R2 read data", rd, ref_mem[a]);
      @(negedge clk);
      chk(!rsp_valid, "R2 single pulse", rsp_valid, 0);
    end
    // single-lane writes
    for (int a = 0; a < DEPTH; a++) begin
      logic [1:0] m = (a % 2 == 0) ? 2'b01 : 2'b10;
      do_req(1, a[AW-1:0], ~pat(a), m, bz, rd, got);
      if (m[0]) ref_mem[a][7:0]  = ~pat(a) >> 0;
      if (m[1]) ref_mem[a][15:8] = 8'((~pat(a)) >> 8);
    end
    // reads with all mask patterns
    for (int a = 0; a < DEPTH; a++) begin
      for (int k = 1; k < 4; k++) begin
        do_req(0, a[AW-1:0], '0, k[1:0], bz, rd, got);
        chk(got && rd == lanes(ref_mem[a], k[1:0]), "R5 R6 lane read", rd, lanes(ref_mem[a], k[1:0]));
      end
    end
    // zero-mask requests
    for (int a = 0; a < 8; a++) begin
      sc = sel_cnt;
      do_req(1, a[AW-1:0], 16'h1234, 2'b00, bz, rd, got);
      chk(bz == 0 && sel_cnt == sc, "R9 zero-mask write no access", sel_cnt - sc, 0);
      sc = sel_cnt;
      do_req(0, a[AW-1:0], '0, 2'b00, bz, rd, got);
      chk(bz == 0 && sel_cnt == sc, "R9 zero-mask read no access", sel_cnt - sc, 0);
      chk(got && rd == 0, "R9 zero-mask read response", rd, 0);
      do_req(0, a[AW-1:0], '0, 2'b11, bz, rd, got);
      chk(rd == ref_mem[a], "R9 memory unchanged", rd, ref_mem[a]);
    end
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule